// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Prediction

This block predicts the next fetch address for an instruction fetch stage. The fetch PC selects one entry of a direct-mapped table and is compared with the tag stored there. The lookup is combinational, so the answer is ready in the same fetch cycle. On a match, each entry's two-bit saturating counter decides whether the stored target is used. On a miss, or when the counter leans toward not-taken, the fetch stage gets the sequential address PC+4.

A later pipeline stage resolves each branch and sends back its PC, its outcome and its real target on an update port. A taken branch that misses claims its slot and starts at weakly taken. A not-taken branch that misses leaves the table alone. A branch that hits steps its counter up or down. Because of this hysteresis, leaving a loop once does not flip the prediction, so re-entering the loop costs a single misprediction and not two. The pipeline reacts to mispredictions on its own and does not use this block for that.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until an update allocates an entry.
- R2: When the lookup misses, or hits with counter value 0 or 1, next_pc_o equals fetch_pc_i + 4 (modulo 2^PC_W) and pred_taken_o is 0.
- R3: When the lookup hits with counter value 2 or 3, pred_taken_o is 1 and next_pc_o is the stored target. pred_taken_o is never 1 without pred_hit_o.
- R4: The entry index is PC bits [IDX_W+1:2] (bits 5:2 by default) and the tag is the bits above them. PC bits 1:0 have no effect on which entry is selected or matched.
- R5: A taken update whose PC misses writes the entry: it becomes valid with the new tag, the reported target and counter value 2 (weakly taken).
- R6: A not-taken update whose PC misses changes no entry.
- R7: An update that hits steps the counter: +1 when taken, -1 when not taken, held between 0 and 3. From 3, one not-taken outcome still leaves a taken prediction.
- R8: A taken update that hits replaces the stored target with the reported one. A not-taken update that hits keeps the stored target.
- R9: A lookup and an update in the same cycle read the table contents from before the update. The update shows on lookups from the next cycle on.
- R10: A taken update with a different tag at an occupied index replaces that entry, and the old PC then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | PC_W | PC of the instruction being fetched |
| pred_hit_o | output | 1 | Valid entry with matching tag |
| pred_taken_o | output | 1 | Branch predicted taken |
| next_pc_o | output | PC_W | Predicted next fetch address |
| upd_valid_i | input | 1 | Resolved branch report present |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |
| upd_target_i | input | PC_W | Actual branch target |

## Verification
Most faults in this block show up on next_pc_o or pred_taken_o for the first fetch of the affected PC after the faulty update, one cycle later. Examples are a wrong counter step, a counter that wraps instead of saturating, a lost or unwanted allocation, a stale target, or a tag compared against the wrong bits. A fault in the same-cycle order would show in the very cycle of the update. Randomized streams over a small PC pool give frequent hits, index conflicts and collisions between lookup and update, and every cycle is compared with a reference table held in the bench. Directed sequences walk the counter through both saturation points and through loop-exit hysteresis.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  function automatic logic ctr_predicts_taken(ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/btb_pc_split.sv
module btb_pc_split #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  localparam int TAG_W = PC_W - IDX_W - 2
) (
  input  logic [PC_W-1:2]  pc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [TAG_W-1:0] tag_o
);
  assign idx_o = pc_i[IDX_W+1:2];
  assign tag_o = pc_i[PC_W-1:IDX_W+2];
endmodule

// File: rtl/btb_ctr_step.sv
module btb_ctr_step
  import btb_pkg::*;
(
  input  ctr_t ctr_i,
  input  logic taken_i,
  output ctr_t ctr_o
);
  always_comb begin
    ctr_o = ctr_i;
    if (taken_i) begin
      if (ctr_i != CTR_ST) ctr_o = ctr_i + 2'd1;
    end else begin
      if (ctr_i != CTR_SNT) ctr_o = ctr_i - 2'd1;
    end
  end
endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = PC_W - IDX_W - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  // lookup port
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic [PC_W-1:0]  rd_tgt_o,
  output ctr_t             rd_ctr_o,
  // update port
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic [TAG_W-1:0] upd_tag_i,
  input  logic             upd_taken_i,
  input  logic [PC_W-1:0]  upd_tgt_i
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  ctr_t               ctr_q [ENTRIES];

  logic       u_hit, wr_en;
  ctr_t       u_ctr, stepped_ctr, new_ctr;
  logic [PC_W-1:0] new_tgt;

  // reads see pre-update contents
  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_tgt_o   = tgt_q[rd_idx_i];
  assign rd_ctr_o   = ctr_q[rd_idx_i];

  assign u_ctr = ctr_q[upd_idx_i];
  assign u_hit = valid_q[upd_idx_i] && (tag_q[upd_idx_i] == upd_tag_i);

  btb_ctr_step u_step (
    .ctr_i   (u_ctr),
    .taken_i (upd_taken_i),
    .ctr_o   (stepped_ctr)
  );

  // not-taken misses never allocate
  assign wr_en   = upd_en_i && (u_hit || upd_taken_i);
  assign new_ctr = u_hit ? stepped_ctr : CTR_WT;
  assign new_tgt = upd_taken_i ? upd_tgt_i : tgt_q[upd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        tag_q[e] <= '0;
        tgt_q[e] <= '0;
        ctr_q[e] <= CTR_SNT;
      end
    end else if (wr_en) begin
      valid_q[upd_idx_i] <= 1'b1;
      tag_q[upd_idx_i]   <= upd_tag_i;
      tgt_q[upd_idx_i]   <= new_tgt;
      ctr_q[upd_idx_i]   <= new_ctr;
    end
  end

  p_alloc_weak_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_taken_i && !u_hit) |=>
      (valid_q[$past(upd_idx_i)] && ctr_q[$past(upd_idx_i)] == CTR_WT &&
       tgt_q[$past(upd_idx_i)] == $past(upd_tgt_i)));

  p_no_alloc_nt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !upd_taken_i && !u_hit) |=> $stable(valid_q));

  p_sat_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_taken_i && u_hit && ctr_q[upd_idx_i] == CTR_ST) |=>
      (ctr_q[$past(upd_idx_i)] == CTR_ST));

  p_sat_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !upd_taken_i && u_hit && ctr_q[upd_idx_i] == CTR_SNT) |=>
      (ctr_q[$past(upd_idx_i)] == CTR_SNT));
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = PC_W - IDX_W - 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic            pred_hit_o,
  output logic            pred_taken_o,
  output logic [PC_W-1:0] next_pc_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic [PC_W-1:0] upd_target_i
);
  localparam logic [PC_W-1:0] SEQ_STEP = PC_W'(4);

  logic [IDX_W-1:0] f_idx, u_idx;
  logic [TAG_W-1:0] f_tag, u_tag, rd_tag;
  logic             rd_valid;
  logic [PC_W-1:0]  rd_tgt;
  ctr_t             rd_ctr;
  logic             unused_lo;

  assign unused_lo = ^upd_pc_i[1:0];

  btb_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_f (
    .pc_i (fetch_pc_i[PC_W-1:2]), .idx_o (f_idx), .tag_o (f_tag)
  );

  btb_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_u (
    .pc_i (upd_pc_i[PC_W-1:2]), .idx_o (u_idx), .tag_o (u_tag)
  );

  btb_store #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (f_idx),
    .rd_valid_o  (rd_valid),
    .rd_tag_o    (rd_tag),
    .rd_tgt_o    (rd_tgt),
    .rd_ctr_o    (rd_ctr),
    .upd_en_i    (upd_valid_i),
    .upd_idx_i   (u_idx),
    .upd_tag_i   (u_tag),
    .upd_taken_i (upd_taken_i),
    .upd_tgt_i   (upd_target_i)
  );

  assign pred_hit_o   = rd_valid && (rd_tag == f_tag);
  assign pred_taken_o = pred_hit_o && ctr_predicts_taken(rd_ctr);
  assign next_pc_o    = pred_taken_o ? rd_tgt : fetch_pc_i + SEQ_STEP;

  p_taken_needs_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_taken_o |-> pred_hit_o);

  p_seq_on_miss_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_hit_o |-> (next_pc_o == fetch_pc_i + SEQ_STEP));
endmodule

// File: tb/btb_predictor_tb.sv
`timescale 1ns/1ps
module btb_predictor_tb;
  localparam int PC_W = 32;
  localparam int ENTRIES = 16;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0, upd_pc = '0, upd_tgt = '0;
  logic upd_valid = 1'b0, upd_taken = 1'b0;
  logic hit, taken;
  logic [PC_W-1:0] next_pc;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference table
  bit              m_valid [ENTRIES];
  logic [PC_W-1:0] m_tag   [ENTRIES];
  logic [PC_W-1:0] m_tgt   [ENTRIES];
  int              m_ctr   [ENTRIES];

  always #2 clk = ~clk;

  btb_predictor #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .fetch_pc_i (fetch_pc),
    .pred_hit_o (hit), .pred_taken_o (taken), .next_pc_o (next_pc),
    .upd_valid_i (upd_valid), .upd_pc_i (upd_pc),
    .upd_taken_i (upd_taken), .upd_target_i (upd_tgt)
  );

  function automatic int idx_of(logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic logic [PC_W-1:0] tag_of(logic [PC_W-1:0] pc);
    return pc >> (IDX_W + 2);
  endfunction

  task automatic model_update(logic uv, logic [PC_W-1:0] upc, logic ut, logic [PC_W-1:0] utg);
    int i;
    bit h;
    if (!uv) return;
    i = idx_of(upc);
    h = m_valid[i] && (m_tag[i] == tag_of(upc));
    if (h) begin
      if (ut) begin
        if (m_ctr[i] < 3) m_ctr[i]++;
        m_tgt[i] = utg;
      end else if (m_ctr[i] > 0) m_ctr[i]--;
    end else if (ut) begin
      m_valid[i] = 1; m_tag[i] = tag_of(upc); m_tgt[i] = utg; m_ctr[i] = 2;
    end
  endtask

  task automatic step(logic [PC_W-1:0] lpc, logic uv, logic [PC_W-1:0] upc,
                      logic ut, logic [PC_W-1:0] utg, string req);
    int i;
    bit eh, et;
    logic [PC_W-1:0] en;
    string r;
    @(negedge clk);
    fetch_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_tgt = utg;
    #1;
    i  = idx_of(lpc);
    eh = m_valid[i] && (m_tag[i] == tag_of(lpc));
    et = eh && (m_ctr[i] >= 2);
    en = et ? m_tgt[i] : lpc + 32'd4;
    r  = (req != "") ? req : (et ? "R3" : "R2");
    checks++;
    if (hit !== eh || taken !== et || next_pc !== en) begin
      failures++;
      $display("FAIL %s pc=%h actual hit=%b taken=%b next=%h expected hit=%b taken=%b next=%h",
               r, lpc, hit, taken, next_pc, eh, et, en);
    end
    @(posedge clk);
    model_update(uv, upc, ut, utg);
  endtask

  task automatic look(logic [PC_W-1:0] lpc, string req);
    step(lpc, 1'b0, '0, 1'b0, '0, req);
  endtask

  task automatic upd(logic [PC_W-1:0] upc, logic ut, logic [PC_W-1:0] utg, string req);
    step(upc ^ 32'h8000_0000, 1'b1, upc, ut, utg, req);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [PC_W-1:0] pa, pb, t1, t2, t3;
    void'($urandom(32'd4242));
    for (int e = 0; e < ENTRIES; e++) begin
      m_valid[e] = 0; m_tag[e] = '0; m_tgt[e] = '0; m_ctr[e] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1: empty table after reset
    look(32'h0000_0000, "R1");
    look(32'h0000_103c, "R1");
    look(32'hffff_fffc, "R1"); // R2 wraps to 0

    pa = 32'h0000_0148; // idx 2
    pb = 32'h0000_0548; // same idx, other tag
    t1 = 32'h0000_2000; t2 = 32'h0000_3000; t3 = 32'h0000_4000;

    upd(pa, 1'b0, t1, "R6");
    look(pa, "R6");                 // still miss
    upd(pa, 1'b1, t1, "R5");
    look(pa, "R5");                 // hit weak taken -> t1
    look(pa | 32'h3, "R4");         // low bits ignored
    look(pa ^ 32'h0000_0004, "R4"); // other index misses
    upd(pa, 1'b0, t3, "R7");        // 2 -> 1
    look(pa, "R7");                 // hit, not taken
    upd(pa, 1'b1, t2, "R8");        // 1 -> 2, target t2
    look(pa, "R8");
    upd(pa, 1'b1, t2, "R7");        // 3
    upd(pa, 1'b1, t2, "R7");        // saturated 3
    upd(pa, 1'b0, t3, "R7");        // 2, loop exit keeps taken
    look(pa, "R8");                 // target kept t2
    upd(pa, 1'b0, t3, "R7");
    upd(pa, 1'b0, t3, "R7");
    upd(pa, 1'b0, t3, "R7");        // saturated 0
    upd(pa, 1'b1, t1, "R7");        // 1: not taken
    look(pa, "R7");
    upd(pa, 1'b1, t1, "R7");        // 2
    // R9: lookup pa while pb replaces same slot
    step(pa, 1'b1, pb, 1'b1, t3, "R9");
    look(pa, "R10");
    look(pb, "R10");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [PC_W-1:0] lp, up, tg;
      lp = ($urandom_range(0, 3) << 6) | ($urandom_range(0, 15) << 2) | $urandom_range(0, 3);
      up = ($urandom_range(0, 3) << 6) | ($urandom_range(0, 15) << 2) | $urandom_range(0, 3);
      tg = $urandom;
      if ($urandom_range(0, 3) == 0) up = lp; // R9 collisions
      step(lp, ($urandom_range(0, 1) == 1), up, ($urandom_range(0, 2) != 0), tg, "");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule